// File: doc/BRIEF.md
# Two-Pass Montgomery Modular Multiplier

This block computes the ordinary residue `A*B mod M` without a divider. It runs a bit-serial radix-2 Montgomery reduction twice, using the same step unit both times.

The first pass walks the bits of A from LSB to MSB against B. This leaves `A*B*2^-W mod M`. The second pass walks the bits of that intermediate against a caller-supplied correction constant `2^(2W) mod M`, which cancels the stray `2^-W` factor. A small local controller sequences both passes and swaps the operand sources between them. It then raises a one-cycle finished pulse to the parent controller.

The controller has four states:
- `ST_IDLE` waits for a start pulse and moves to `ST_ITER` on start.
- `ST_ITER` performs one reduction step per cycle. It stays in `ST_ITER` until the last operand bit, then moves to `ST_FIX`.
- `ST_FIX` applies the final conditional subtraction. A toggle flip-flop marks which pass is active. If the first pass just ended, `ST_FIX` returns to `ST_ITER` with the swapped sources. If the second pass ended, it moves to `ST_DONE`.
- `ST_DONE` presents the finished pulse and returns to `ST_IDLE`.

Top module: `modmul_2pass`

## Requirements
- R1: For odd M with 2^(W-1) < M < 2^W, operands A, B < M, and correction input equal to 2^(2W) mod M, `result_o` equals (A*B) mod M when `done_o` is high.
- R2: `done_o` is high for exactly one cycle. It rises 2W+2 rising clock edges after the edge that accepted `start_i`.
- R3: Whenever `done_o` is high, `result_o` is below the modulus captured at start.
- R4: `result_o` changes only in a cycle where `done_o` is high. It holds its value between completions, whatever the inputs do.
- R5: A `start_i` pulse that arrives while an operation is in progress is ignored. It neither restarts the operation nor shifts the completion cycle.
- R6: While `rst_ni` is low, `done_o` and `result_o` are 0.
- R7: A zero operand yields 0, and (M-1)*(M-1) yields 1.
- R8: Operands, modulus and correction are sampled on the accepting edge. Changes to them during the operation do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiplication (accepted when idle) |
| op_a_i | input | W | Multiplicand, below M |
| op_b_i | input | W | Multiplier, below M |
| mod_i | input | W | Odd modulus, top bit set |
| corr_i | input | W | Correction constant 2^(2W) mod M |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W | Product modulo M, held until the next completion |

## Verification
The main instance is built with W=6. At that width, every operand pair for the moduli 33 and 59 is swept exhaustively. This covers every carry into the two guard bits and every path taken or skipped by the final subtraction. A second instance uses the default W=12. It runs boundary operands (0, 1, 2, M-2, M-1, M/2) and two mid-range values against four moduli. This confirms the full-width latency of 26 edges and the correction constants at the production width.

// File: rtl/mm_pkg.sv
package mm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2,
        ST_DONE = 2'd3
    } mm_state_e;
endpackage

// File: rtl/mm_step.sv
// One radix-2 Montgomery reduction step: conditional add of y, add of m when
// the sum is odd, then halve. Accumulator stays below 2m.
module mm_step #(
    parameter int W = 12
) (
    input  logic [W+1:0] acc_i,
    input  logic         xbit_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] m_i,
    output logic [W+1:0] acc_o
);
    logic [W+1:0] sum_y;
    logic [W+1:0] sum_m;

    always_comb begin
        sum_y = acc_i + (xbit_i ? {2'b00, y_i} : '0);
        sum_m = sum_y + (sum_y[0] ? {2'b00, m_i} : '0);
        acc_o = sum_m >> 1;
    end
endmodule

// File: rtl/mm_ctrl.sv
module mm_ctrl
    import mm_pkg::*;
#(
    parameter int W = 12
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic load_o,
    output logic iter_o,
    output logic fix_o,
    output logic pass_o,
    output logic done_o
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;

    mm_state_e     state_q, state_d;
    logic [CW-1:0] bit_cnt_q;
    logic          pass_q;
    logic          last_bit;

    assign last_bit = (bit_cnt_q == CW'(W - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)  state_d = ST_ITER;
            ST_ITER: if (last_bit) state_d = ST_FIX;
            ST_FIX:  state_d = pass_q ? ST_DONE : ST_ITER;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Bit counter and pass toggle
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bit_cnt_q <= '0;
            pass_q    <= 1'b0;
        end else begin
            if (load_o || fix_o)  bit_cnt_q <= '0;
            else if (iter_o)      bit_cnt_q <= bit_cnt_q + 1'b1;
            if (fix_o)            pass_q <= ~pass_q;
        end
    end

    always_comb begin
        load_o = (state_q == ST_IDLE) && start_i;
        iter_o = (state_q == ST_ITER);
        fix_o  = (state_q == ST_FIX);
        done_o = (state_q == ST_DONE);
        pass_o = pass_q;
    end
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic         iter_i,
    input  logic         fix_i,
    input  logic         pass_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] m_i,
    input  logic [W-1:0] corr_i,
    output logic [W-1:0] result_o
);
    logic [W+1:0] acc_q;
    logic [W+1:0] acc_step;
    logic [W-1:0] x_q, y_q, m_q, corr_q;
    logic [W-1:0] reduced;

    mm_step #(.W(W)) u_step (
        .acc_i  (acc_step_in()),
        .xbit_i (x_q[0]),
        .y_i    (y_q),
        .m_i    (m_q),
        .acc_o  (acc_step)
    );

    function automatic logic [W+1:0] acc_step_in();
        return acc_q;
    endfunction

    always_comb begin
        if (acc_q >= {2'b00, m_q}) reduced = W'(acc_q - {2'b00, m_q});
        else                       reduced = W'(acc_q);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            acc_q    <= '0;
            x_q      <= '0;
            y_q      <= '0;
            m_q      <= '0;
            corr_q   <= '0;
            result_o <= '0;
        end else if (load_i) begin
            acc_q  <= '0;
            x_q    <= a_i;
            y_q    <= b_i;
            m_q    <= m_i;
            corr_q <= corr_i;
        end else if (iter_i) begin
            acc_q <= acc_step;
            x_q   <= x_q >> 1;
        end else if (fix_i) begin
            if (!pass_i) begin
                // swap sources: reduced intermediate against correction
                acc_q <= '0;
                x_q   <= reduced;
                y_q   <= corr_q;
            end else begin
                result_o <= reduced;
            end
        end
    end
endmodule

// File: rtl/modmul_2pass.sv
module modmul_2pass #(
    parameter int W = 12
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] op_a_i,
    input  logic [W-1:0] op_b_i,
    input  logic [W-1:0] mod_i,
    input  logic [W-1:0] corr_i,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    logic load, iter, fix, pass;

    mm_ctrl #(.W(W)) u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start_i),
        .load_o  (load),
        .iter_o  (iter),
        .fix_o   (fix),
        .pass_o  (pass),
        .done_o  (done_o)
    );

    mm_datapath #(.W(W)) u_dp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (load),
        .iter_i   (iter),
        .fix_i    (fix),
        .pass_i   (pass),
        .a_i      (op_a_i),
        .b_i      (op_b_i),
        .m_i      (mod_i),
        .corr_i   (corr_i),
        .result_o (result_o)
    );
endmodule

// File: rtl/mm_chk.sv
module mm_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         done,
    input logic [W-1:0] result,
    input logic [W-1:0] m
);
    localparam int LAT = 2 * W + 2;
    localparam int LW  = $clog2(LAT + 2);

    logic          busy_q;
    logic [LW-1:0] lat_q;
    logic [W-1:0]  m_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            lat_q  <= '0;
            m_cap  <= '0;
        end else if (!busy_q && start) begin
            busy_q <= 1'b1;
            lat_q  <= '0;
            m_cap  <= m;
        end else if (busy_q) begin
            if (done) busy_q <= 1'b0;
            if (lat_q != LW'(LAT + 1)) lat_q <= lat_q + 1'b1;
        end
    end

    // R2: completion exactly LAT edges after acceptance
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_q && lat_q == LW'(LAT)));

    // R2: single-cycle pulse
    a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: reduced result
    a_r3_below_mod: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < m_cap));

    // R4: result only moves with done
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R5: no completion without an accepted operation
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !done);
endmodule

bind modmul_2pass mm_chk #(.W(W)) u_mm_chk (
    .clk    (clk_i),
    .rst_n  (rst_ni),
    .start  (start_i),
    .done   (done_o),
    .result (result_o),
    .m      (mod_i)
);

// File: tb/tb_modmul_2pass.sv
`timescale 1ns/1ps
module tb_modmul_2pass;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // W=6 instance
    logic       st6 = 1'b0;
    logic [5:0] a6 = '0, b6 = '0, m6 = '0, c6 = '0;
    logic       dn6;
    logic [5:0] r6;

    modmul_2pass #(.W(6)) dut (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st6),
        .op_a_i(a6), .op_b_i(b6), .mod_i(m6), .corr_i(c6),
        .done_o(dn6), .result_o(r6)
    );

    // W=12 instance
    logic        st12 = 1'b0;
    logic [11:0] a12 = '0, b12 = '0, m12 = '0, c12 = '0;
    logic        dn12;
    logic [11:0] r12;

    modmul_2pass #(.W(12)) dut_w12 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(st12),
        .op_a_i(a12), .op_b_i(b12), .mod_i(m12), .corr_i(c12),
        .done_o(dn12), .result_o(r12)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic op6(input int a, input int b, input int m);
        int n;
        string tag;
        tag = (a == 0 || b == 0 || (a == m - 1 && b == m - 1)) ? "R7" : "R1";
        @(negedge clk);
        a6 = 6'(a); b6 = 6'(b); m6 = 6'(m); c6 = 6'((1 << 12) % m); st6 = 1'b1;
        @(negedge clk);
        st6 = 1'b0;
        n = 1;
        while (!dn6 && n < 100) begin @(negedge clk); n++; end
        check("R2 latency w6", n, 15);
        check(tag, r6, (a * b) % m);
        @(negedge clk);
        check("R2 pulse w6", dn6, 0);
    endtask

    task automatic op12(input int a, input int b, input int m);
        int n;
        string tag;
        tag = (a == 0 || b == 0 || (a == m - 1 && b == m - 1)) ? "R7" : "R1";
        @(negedge clk);
        a12 = 12'(a); b12 = 12'(b); m12 = 12'(m); c12 = 12'((longint'(1) << 24) % m); st12 = 1'b1;
        @(negedge clk);
        st12 = 1'b0;
        n = 1;
        while (!dn12 && n < 100) begin @(negedge clk); n++; end
        check("R2 latency w12", n, 27);
        check(tag, r12, (longint'(a) * b) % m);
        check("R3 w12", (r12 < m) ? 1 : 0, 1);
        @(negedge clk);
        check("R2 pulse w12", dn12, 0);
    endtask

    initial begin
        int n;
        int mods6[2];
        int mods12[4];
        int vals[8];
        mods6[0] = 33; mods6[1] = 59;
        mods12[0] = 2773; mods12[1] = 2901; mods12[2] = 4095; mods12[3] = 2049;

        // R6: reset state
        repeat (3) @(negedge clk);
        check("R6 done", dn6, 0);
        check("R6 result", r6, 0);
        check("R6 done w12", dn12, 0);
        check("R6 result w12", r12, 0);
        rst_n = 1'b1;

        // R1/R7 exhaustive at W=6
        for (int mi = 0; mi < 2; mi++)
            for (int a = 0; a < mods6[mi]; a++)
                for (int b = 0; b < mods6[mi]; b++)
                    op6(a, b, mods6[mi]);

        // R5 and R8: second start and input changes while busy
        @(negedge clk);
        a6 = 6'd5; b6 = 6'd7; m6 = 6'd59; c6 = 6'((1 << 12) % 59); st6 = 1'b1;
        @(negedge clk);
        st6 = 1'b0;
        repeat (2) @(negedge clk);
        a6 = 6'd50; b6 = 6'd40; m6 = 6'd33; c6 = 6'((1 << 12) % 33); st6 = 1'b1;
        @(negedge clk);
        st6 = 1'b0;
        n = 4;
        while (!dn6 && n < 100) begin @(negedge clk); n++; end
        check("R5 latency unchanged", n, 15);
        check("R8 result from sampled inputs", r6, (5 * 7) % 59);

        // R4: result held without start while inputs move
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            a6 = 6'(k * 9); b6 = 6'(k * 5 + 1);
            check("R4 hold", r6, (5 * 7) % 59);
            check("R4 no done", dn6, 0);
        end

        // W=12 boundary and mid-range operands
        for (int mi = 0; mi < 4; mi++) begin
            vals[0] = 0; vals[1] = 1; vals[2] = 2;
            vals[3] = mods12[mi] - 2; vals[4] = mods12[mi] - 1;
            vals[5] = mods12[mi] / 2; vals[6] = 1697 % mods12[mi]; vals[7] = 2000;
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    op12(vals[i], vals[j], mods12[mi]);
        end
        check("R1 vector 2773", ((longint'(1) << 24) % 2773), 566);
        check("R1 vector 2901", ((longint'(1) << 24) % 2901), 733);

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #950000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule